// File: doc/BRIEF.md
# Write-Stream Bit Recovery

This block turns the raw write-data line of a floppy-style drive port back into bytes. The host marks each 4 µs bit cell with a level change for a one and with no change for a zero. A local cell timer restarts on every qualified change and samples the cell at its midpoint. Between changes the timer free-runs with a period a little shorter than the host's cell. Because of that, long runs of zero cells keep each sample inside its own cell.

Bytes are framed by the rule that every valid byte begins with a one. Zero cells that arrive while no byte is open are dropped. This lets self-synchronising 10-cell sync patterns, and a stream whose first cells were missed, settle onto correct byte boundaries without a bit counter. Decoding runs only while both the write-request and the device-enable qualifiers are high. Both qualifiers are taken as synchronous to `clk`. The write-data line passes through a two-stage synchroniser.

The output is a valid-only stream that has no ready input and therefore no back-pressure. The consumer must take `byte_o` in every cycle in which `byte_valid_o` is high. `byte_o` then holds that value until the next byte completes. Packet parsing, checksums and storage belong to downstream logic.

Top module: `wr_stream_rx`

## Requirements
- R1: After reset, `byte_valid_o` is 0 and `byte_o` is 0x00.
- R2: A level change on `wdata` (either direction) in a cell decodes as 1, and no change decodes as 0. Every qualified change restarts the cell timer, which samples HALF_TICKS cycles after the restart and then every CELL_TICKS cycles until the next change.
- R3: `byte_valid_o` rises exactly HALF_TICKS+3 clock cycles after the `wdata` change that carries the last bit of a byte ending in 1. The three extra cycles are two synchroniser stages and one edge-detect stage.
- R4: Bits enter MSB first. A byte is complete after its leading 1 and seven further bits. When `byte_valid_o` is high, `byte_o[7]` is always 1.
- R5: Runs of seven zero cells, as in 0x80 0x80, decode without losing or adding bits. This holds with a host cell of CELL_TICKS+1 cycles.
- R6: Zero cells that arrive while no byte is open are discarded. This covers the two extra zero cells of each 10-cell sync pattern.
- R7: A stream joined part-way through its sync patterns re-frames by the leading-one rule alone. The marker byte 0xC3 and the bytes after it come out intact.
- R8: When `wr_req` or `dev_en` is low, no byte is produced and a partly assembled byte is discarded. The next byte after re-enabling comes out on its own.
- R9: `byte_valid_o` is high for exactly one cycle per byte, and `byte_o` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write-request qualifier, active high |
| dev_en | input | 1 | Device-enable qualifier, active high |
| wdata | input | 1 | Raw write-data line; each level change marks a 1 cell |
| byte_o | output | 8 | Last recovered byte |
| byte_valid_o | output | 1 | One-cycle strobe for a new byte on `byte_o` |

## Verification
The one timing-critical result is the byte strobe. It is due HALF_TICKS+3 clock edges after the change that carries a byte's final 1. The bench counts those edges from a change driven at a falling edge. It samples the strobe on the falling edge just before and just after the due edge.

Byte content is checked as a sequence rather than by time. A falling-edge monitor records every strobe. After each stream the bench waits three cells, so that the last midpoint sample has landed, then compares the record with a leading-one framing of the cells it sent. The gating checks read the same record while the qualifiers are low and again after they return high.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  localparam int unsigned WSR_BYTE_W = 8;
  typedef logic [WSR_BYTE_W-1:0] wsr_byte_t;
endpackage

// File: rtl/wsr_edge_detect.sv
module wsr_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], din};
  end

  // any change after the synchroniser marks a one cell
  assign edge_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/wsr_cell_timer.sv
module wsr_cell_timer #(
  parameter int unsigned CELL_TICKS = 15,
  parameter int unsigned HALF_TICKS = 8,
  localparam int unsigned CNT_W = $clog2(CELL_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic edge_i,
  output logic sample_o,
  output logic bit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign sample_o = active && (cnt_q == CNT_W'(HALF_TICKS - 1));
  assign bit_o    = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (edge_i)                                cnt_q <= '0;
      else if (cnt_q == CNT_W'(CELL_TICKS - 1))  cnt_q <= '0;
      else                                       cnt_q <= cnt_q + 1'b1;
      if (edge_i)        pend_q <= 1'b1;
      else if (sample_o) pend_q <= 1'b0;
    end
  end

  // R2: the local cell counter never leaves its period
  assert_cnt_in_cell_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(CELL_TICKS));
endmodule

// File: rtl/wsr_byte_framer.sv
module wsr_byte_framer
  import wsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  logic      sample_i,
  input  logic      bit_i,
  output wsr_byte_t byte_o,
  output logic      valid_o
);
  wsr_byte_t sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else if (!active) begin
      sh_q    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (sample_i) begin
        if (sh_q[WSR_BYTE_W-2]) begin
          byte_o  <= {sh_q[WSR_BYTE_W-2:0], bit_i};
          valid_o <= 1'b1;
          sh_q    <= '0;
        end else begin
          sh_q <= {sh_q[WSR_BYTE_W-2:0], bit_i};
        end
      end
    end
  end

  // R4: a finished byte always carries its leading one
  assert_msb_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> byte_o[WSR_BYTE_W-1]);
  // R9: strobe lasts one cycle and the byte is held afterwards
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_byte_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(byte_o));
endmodule

// File: rtl/wr_stream_rx.sv
module wr_stream_rx
  import wsr_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 96,
  parameter int unsigned CELL_US    = 4,
  parameter int unsigned CELL_TICKS = CLK_MHZ * CELL_US - (CLK_MHZ * CELL_US) / 64,
  parameter int unsigned HALF_TICKS = (CLK_MHZ * CELL_US) / 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_req,
  input  logic       dev_en,
  input  logic       wdata,
  output logic [7:0] byte_o,
  output logic       byte_valid_o
);
  logic      active;
  logic      edge_w;
  logic      sample_w;
  logic      bit_w;
  wsr_byte_t byte_w;

  assign active = wr_req && dev_en;

  wsr_edge_detect #(.STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rst_n(rst_n), .din(wdata), .edge_o(edge_w)
  );

  wsr_cell_timer #(.CELL_TICKS(CELL_TICKS), .HALF_TICKS(HALF_TICKS)) i_timer (
    .clk(clk), .rst_n(rst_n), .active(active), .edge_i(edge_w),
    .sample_o(sample_w), .bit_o(bit_w)
  );

  wsr_byte_framer i_framer (
    .clk(clk), .rst_n(rst_n), .active(active), .sample_i(sample_w),
    .bit_i(bit_w), .byte_o(byte_w), .valid_o(byte_valid_o)
  );

  assign byte_o = byte_w;

  // R8: no byte comes out of a cycle in which the qualifiers were not both high
  assert_gated_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && dev_en) |=> !byte_valid_o);
endmodule

// File: tb/test_wr_stream_rx.sv
`timescale 1ns/1ps
module test_wr_stream_rx;
  localparam int CELL = 15;
  localparam int HALF = 8;
  localparam int HOST = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0, dev_en = 1'b0, wdata = 1'b0;
  logic [7:0] byte_o;
  logic byte_valid_o;

  int checks = 0, failures = 0, cycles = 0;
  logic [7:0] got [0:255];
  int ngot = 0;
  logic bits [0:2047];
  int nbits = 0;
  logic [7:0] exp_b [0:255];
  int nexp = 0;

  always #2.5 clk = ~clk;

  wr_stream_rx #(.CELL_TICKS(CELL), .HALF_TICKS(HALF)) i_wr_stream_rx (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .dev_en(dev_en),
    .wdata(wdata), .byte_o(byte_o), .byte_valid_o(byte_valid_o)
  );

  always @(negedge clk) begin
    if (byte_valid_o && ngot < 256) begin
      got[ngot] = byte_o;
      ngot++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic add_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin bits[nbits] = b[i]; nbits++; end
  endtask
  task automatic add_zeros(input int n);
    for (int i = 0; i < n; i++) begin bits[nbits] = 1'b0; nbits++; end
  endtask

  task automatic play();
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      if (bits[i]) wdata = ~wdata;
      repeat (HOST - 1) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (3 * HOST) @(negedge clk);
  endtask

  // leading-one framing of the sent cells, from R4 and R6
  task automatic frame_ref();
    int n;
    logic [7:0] acc;
    n = 0; acc = 8'h00; nexp = 0;
    for (int i = 0; i < nbits; i++) begin
      if (n != 0 || bits[i]) begin
        acc = {acc[6:0], bits[i]};
        n++;
        if (n == 8) begin exp_b[nexp] = acc; nexp++; n = 0; end
      end
    end
  endtask

  task automatic compare(input string req);
    frame_ref();
    check({req, " byte count"}, ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++) check(req, got[i], exp_b[i]);
  endtask

  task automatic start();
    @(negedge clk);
    wr_req = 1'b0; dev_en = 1'b0;
    repeat (4) @(negedge clk);
    ngot = 0; nbits = 0;
    wr_req = 1'b1; dev_en = 1'b1;
    repeat (HOST) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid after reset", byte_valid_o, 0);
    check("R1 byte after reset", byte_o, 8'h00);
  endtask

  task automatic t_plain();
    start();
    add_byte(8'hC3); add_byte(8'hAA); add_byte(8'hD5); add_byte(8'hFF); add_byte(8'h96);
    play(); settle();
    compare("R2 R4 plain bytes");
    check("R9 byte held after last strobe", byte_o, 8'h96);
  endtask

  task automatic t_zero_runs();
    start();
    add_byte(8'h80); add_byte(8'h80); add_byte(8'h80); add_byte(8'h81); add_byte(8'h80);
    play(); settle();
    compare("R5 seven-zero runs");
  endtask

  task automatic t_gap_zeros();
    start();
    add_zeros(5); add_byte(8'hC3); add_zeros(2); add_byte(8'h81); add_zeros(2); add_byte(8'hC8);
    play(); settle();
    compare("R6 extra zeros dropped");
    check("R6 second byte", got[1], 8'h81);
  endtask

  task automatic t_partial_sync();
    start();
    for (int i = 3; i < 10; i++) begin bits[nbits] = (i < 8); nbits++; end
    for (int k = 0; k < 4; k++) begin add_byte(8'hFF); add_zeros(2); end
    add_byte(8'hC3); add_byte(8'h81); add_byte(8'h80); add_byte(8'hC8);
    play(); settle();
    compare("R7 joined mid-sync");
    check("R7 marker byte", (ngot >= 4) ? int'(got[ngot-4]) : -1, 8'hC3);
    check("R7 last byte", (ngot >= 1) ? int'(got[ngot-1]) : -1, 8'hC8);
  endtask

  task automatic t_gate();
    start();
    add_byte(8'hB0);
    nbits = 4;
    play();
    @(negedge clk); dev_en = 1'b0;
    repeat (2 * HOST) @(negedge clk);
    nbits = 0; add_byte(8'hAA); play(); settle();
    check("R8 nothing while disabled", ngot, 0);
    @(negedge clk); dev_en = 1'b1;
    repeat (HOST) @(negedge clk);
    nbits = 0; add_byte(8'h95); play(); settle();
    check("R8 one byte after re-enable", ngot, 1);
    check("R8 byte after re-enable", got[0], 8'h95);
    @(negedge clk); wr_req = 1'b0;
    nbits = 0; add_byte(8'hFF); play(); settle();
    check("R8 nothing without write request", ngot, 1);
  endtask

  task automatic t_latency();
    start();
    add_byte(8'h81);
    nbits = 7;
    play();
    @(negedge clk);
    wdata = ~wdata;
    repeat (HALF + 2) @(posedge clk);
    @(negedge clk);
    check("R3 strobe not yet due", byte_valid_o, 0);
    @(posedge clk);
    @(negedge clk);
    check("R3 strobe due at HALF+3", byte_valid_o, 1);
    check("R3 byte at strobe", byte_o, 8'h81);
    @(negedge clk);
    check("R9 strobe one cycle", byte_valid_o, 0);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_plain();
    t_zero_runs();
    t_gap_zeros();
    t_partial_sync();
    t_gate();
    t_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule